// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an SDRAM interface. It owns the command pins from reset until the memory is ready to use. It then issues the periodic auto-refresh that the memory needs to keep its contents.

After reset it holds the pins at no-operation, with clock enable and the data masks high, for a stabilization interval. It then issues these commands in a fixed order:

- a precharge of all banks;
- a programmable number of auto-refreshes;
- a mode register load.

Each command waits out the recovery time of the one before it. When the mode-load recovery has elapsed, the block raises `ready_o`.

From then on, an interval timer adds one owed refresh on every interval expiry. The block raises a refresh request while any refresh is owed. The surrounding controller answers with a grant when the command bus is free. The block then drives one auto-refresh and keeps the bus at no-operation for the refresh cycle time. Intervals that expire while a refresh is still owed are counted as misses, and the miss count has an upper limit. Any interval that expires with the count already at that limit sets a sticky saturation flag.

Top module: `sdram_pwrup_refresh_seq`

## Requirements
- R1: For T_PWR cycles after reset is released, the pins carry no-operation ({cs_n,ras_n,cas_n,we_n}=0111), with cke_o=1, dqm_o all ones and ready_o=0.
- R2: In cycle T_PWR (counting from 0 at reset release), the pins carry precharge-all (0010) with address bit 10 high.
- R3: N_INIT_REF auto-refreshes (0001) follow. The first is in cycle T_PWR+T_RP and each later one is T_RC cycles after the previous one, with no-operation in between.
- R4: T_RC cycles after the last start-up refresh, the pins carry mode-register load (0000). The address holds burst-length code in bits 2:0, burst type in bit 3 and CAS latency in bits 6:4. Bits 11:7 and the bank lines are zero.
- R5: ready_o rises T_RSC cycles after the mode load and then stays high. dqm_o drops to zero in the same cycle.
- R6: Counting from the cycle ready_o rises, every T_REFI cycles add one owed refresh. ref_req_o is high while any refresh is owed.
- R7: A grant sampled while a refresh is owed and the bus is idle puts auto-refresh on the pins in the next cycle and clears one owed refresh. No-operation follows for T_RC-1 cycles, and grants during that window have no effect.
- R8: A grant while nothing is owed has no effect: the pins stay at no-operation.
- R9: miss_cnt_o equals the owed count minus one (zero when nothing is owed) and never exceeds MISS_MAX. An interval expiry at that limit sets ref_sat_o, which stays set until reset.
- R10: When an accepted grant and an interval expiry fall on the same edge, the owed count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_grant_i | input | 1 | Bus grant for a pending refresh |
| cke_o | output | 1 | Clock enable to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | 12 | Address lines |
| ba_o | output | 2 | Bank lines |
| dqm_o | output | DQM_W | Data masks |
| ready_o | output | 1 | Start-up sequence complete |
| ref_req_o | output | 1 | Refresh owed |
| miss_cnt_o | output | MISS_W | Refresh intervals missed |
| ref_sat_o | output | 1 | Miss count overflowed (sticky) |

## Verification
Two events can land on the same clock edge: an interval expiry that adds an owed refresh, and an accepted grant that removes one. The bench lets two intervals pass without a grant, then computes the cycle just before an expiry and raises the grant exactly there. The bench then checks that the miss count holds and that auto-refresh appears on the next cycle. The reference model keeps the owed count as a plain integer, updated by the add and remove rules given separately. This applies both to the coincidence and to the later saturation run, where the grant is withheld for several intervals.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    ST_PWR  = 3'd0,
    ST_PREA = 3'd1,
    ST_WAIT = 3'd2,
    ST_IREF = 3'd3,
    ST_MRS  = 3'd4,
    ST_RUN  = 3'd5,
    ST_RREF = 3'd6
  } seq_state_e;
endpackage

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_seq_pkg::*;
#(
  parameter logic [2:0] BL_CODE = 3'd2,
  parameter logic       BT_ILV  = 1'b0,
  parameter logic [2:0] CAS_LAT = 3'd3
) (
  input  seq_state_e  state_i,
  output logic        cs_n_o,
  output logic        ras_n_o,
  output logic        cas_n_o,
  output logic        we_n_o,
  output logic [11:0] addr_o,
  output logic [1:0]  ba_o
);
  localparam logic [11:0] MODE_WORD = {5'b0, CAS_LAT, BT_ILV, BL_CODE};

  always_comb begin
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0111;
    addr_o = '0;
    ba_o   = '0;
    unique case (state_i)
      ST_PREA: begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0010;
        addr_o[10] = 1'b1;
      end
      ST_IREF, ST_RREF: {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0001;
      ST_MRS: begin
        {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b0000;
        addr_o = MODE_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_refi_ctl.sv
module sdram_refi_ctl #(
  parameter int T_REFI   = 1562,
  parameter int MISS_MAX = 8,
  parameter int MISS_W   = $clog2(MISS_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              serve_i,
  output logic              req_o,
  output logic [MISS_W-1:0] miss_cnt_o,
  output logic              sat_o
);
  localparam int RW = $clog2(T_REFI + 1);
  localparam int OW = $clog2(MISS_MAX + 2);
  localparam logic [RW-1:0] REFI_LAST = RW'(T_REFI - 1);
  localparam logic [OW-1:0] OWE_MAX   = OW'(MISS_MAX + 1);

  logic [RW-1:0] refi_q;
  logic [OW-1:0] owed_q;
  logic          tick;

  assign tick = en_i && (refi_q == REFI_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) refi_q <= '0;
    else if (en_i) refi_q <= tick ? '0 : refi_q + RW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
      sat_o  <= 1'b0;
    end else if (serve_i && !tick) begin
      owed_q <= owed_q - OW'(1);
    end else if (tick && !serve_i) begin
      if (owed_q == OWE_MAX) sat_o <= 1'b1;
      else owed_q <= owed_q + OW'(1);
    end
  end

  assign req_o      = (owed_q != '0);
  assign miss_cnt_o = req_o ? MISS_W'(owed_q - OW'(1)) : '0;

  assert_sat_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |=> sat_o);
  assert_miss_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o <= MISS_W'(MISS_MAX));
  assert_sat_at_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_o) |-> $past(miss_cnt_o) == MISS_W'(MISS_MAX));
  assert_req_drop_served_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(serve_i));
  assert_serve_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serve_i |-> req_o);
endmodule

// File: rtl/sdram_pwrup_refresh_seq.sv
module sdram_pwrup_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int T_PWR      = 50000,
  parameter int T_RP       = 3,
  parameter int T_RC       = 7,
  parameter int T_RSC      = 2,
  parameter int N_INIT_REF = 8,
  parameter int T_REFI     = 1562,
  parameter int MISS_MAX   = 8,
  parameter int DQM_W      = 8,
  parameter logic [2:0] BL_CODE = 3'd2,
  parameter logic       BT_ILV  = 1'b0,
  parameter logic [2:0] CAS_LAT = 3'd3,
  parameter int MISS_W     = $clog2(MISS_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_grant_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [11:0]       addr_o,
  output logic [1:0]        ba_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              ready_o,
  output logic              ref_req_o,
  output logic [MISS_W-1:0] miss_cnt_o,
  output logic              ref_sat_o
);
  localparam int M1   = (T_PWR > T_RC) ? T_PWR : T_RC;
  localparam int M2   = (T_RP > T_RSC) ? T_RP : T_RSC;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int NW   = $clog2(N_INIT_REF + 1);
  localparam logic [CW-1:0] LD_PWR = CW'(T_PWR - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 2);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 2);
  localparam logic [CW-1:0] LD_RSC = CW'(T_RSC - 2);
  localparam logic [NW-1:0] IREF_LAST = NW'(N_INIT_REF - 1);

  seq_state_e    state_q, ret_q;
  logic [CW-1:0] cnt_q;
  logic [NW-1:0] iref_q;
  logic          done_q;
  logic          serve;

  assign serve = (state_q == ST_RUN) && ref_req_o && ref_grant_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      ret_q   <= ST_PWR;
      cnt_q   <= LD_PWR;
      iref_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PWR: begin
          if (cnt_q == '0) state_q <= ST_PREA;
          else cnt_q <= cnt_q - CW'(1);
        end
        ST_PREA: begin
          state_q <= ST_WAIT;
          cnt_q   <= LD_RP;
          ret_q   <= ST_IREF;
        end
        ST_IREF: begin
          state_q <= ST_WAIT;
          cnt_q   <= LD_RC;
          ret_q   <= (iref_q == IREF_LAST) ? ST_MRS : ST_IREF;
          iref_q  <= iref_q + NW'(1);
        end
        ST_MRS: begin
          state_q <= ST_WAIT;
          cnt_q   <= LD_RSC;
          ret_q   <= ST_RUN;
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= ret_q;
            if (ret_q == ST_RUN) done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_RUN: if (serve) state_q <= ST_RREF;
        ST_RREF: begin
          state_q <= ST_WAIT;
          cnt_q   <= LD_RC;
          ret_q   <= ST_RUN;
        end
        default: state_q <= ST_PWR;
      endcase
    end
  end

  sdram_cmd_enc #(
    .BL_CODE(BL_CODE), .BT_ILV(BT_ILV), .CAS_LAT(CAS_LAT)
  ) i_enc (
    .state_i (state_q),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .addr_o  (addr_o),
    .ba_o    (ba_o)
  );

  sdram_refi_ctl #(
    .T_REFI(T_REFI), .MISS_MAX(MISS_MAX), .MISS_W(MISS_W)
  ) i_refi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (done_q),
    .serve_i    (serve),
    .req_o      (ref_req_o),
    .miss_cnt_o (miss_cnt_o),
    .sat_o      (ref_sat_o)
  );

  assign cke_o   = 1'b1;
  assign ready_o = done_q;
  assign dqm_o   = done_q ? '0 : '1;

  assert_ready_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  assert_ready_after_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(state_q == ST_WAIT));
  assert_prea_before_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0010) |-> !ready_o && addr_o[10]);
  assert_mrs_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000) |-> (addr_o[11:7] == '0) && (ba_o == '0));
  assert_aref_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0001) |=> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));
endmodule

// File: tb/test_sdram_pwrup_refresh_seq.sv
module test_sdram_pwrup_refresh_seq;
  localparam int T_PWR = 20, T_RP = 3, T_RC = 5, T_RSC = 2, N_REF = 8;
  localparam int T_REFI = 30, MISS_MAX = 3, DQM_W = 8, MISS_W = 2;
  localparam int R_CYC = T_PWR + T_RP + N_REF * T_RC + T_RSC;
  localparam logic [11:0] MODE_EXP = 12'h032;

  logic clk = 1'b0, rst_ni = 1'b0, grant = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, req, sat;
  logic [11:0] addr;
  logic [1:0] ba;
  logic [DQM_W-1:0] dqm;
  logic [MISS_W-1:0] miss;

  int n_chk = 0, n_fail = 0;
  int c = 0, owed = 0, busy = 0;
  bit m_sat = 0, m_aref = 0, r8_evt = 0, r10_evt = 0;

  always #4 clk = ~clk;

  sdram_pwrup_refresh_seq #(
    .T_PWR(T_PWR), .T_RP(T_RP), .T_RC(T_RC), .T_RSC(T_RSC), .N_INIT_REF(N_REF),
    .T_REFI(T_REFI), .MISS_MAX(MISS_MAX), .DQM_W(DQM_W), .MISS_W(MISS_W)
  ) i_sdram_pwrup_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .ref_grant_i(grant), .cke_o(cke),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ba_o(ba), .dqm_o(dqm), .ready_o(ready),
    .ref_req_o(req), .miss_cnt_o(miss), .ref_sat_o(sat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, c);
    end
  endtask

  // reference model: advances once per rising edge after reset release
  always @(posedge clk) if (rst_ni) begin
    bit tick, acc;
    r8_evt = 0; r10_evt = 0; m_aref = 0;
    if (c >= R_CYC) begin
      tick = ((c - R_CYC) % T_REFI) == T_REFI - 1;
      acc  = (busy == 0) && (owed > 0) && grant;
      r8_evt = grant && (busy == 0) && (owed == 0);
      if (acc && tick) r10_evt = 1;
      else if (acc) owed--;
      else if (tick) begin
        if (owed == MISS_MAX + 1) m_sat = 1; else owed++;
      end
      if (acc) busy = T_RC; else if (busy > 0) busy--;
      m_aref = acc;
    end
    c++;
  end

  always @(negedge clk) if (rst_ni) begin
    int k, cmd_e, addr_e;
    string t;
    cmd_e = 4'b0111; addr_e = 0; t = "R1";
    if (c < R_CYC) begin
      k = c - (T_PWR + T_RP);
      if (c == T_PWR) begin cmd_e = 4'b0010; addr_e = 12'h400; t = "R2"; end
      else if (k >= 0 && k < N_REF * T_RC && k % T_RC == 0) begin cmd_e = 4'b0001; t = "R3"; end
      else if (k == N_REF * T_RC) begin cmd_e = 4'b0000; addr_e = MODE_EXP; t = "R4"; end
      else if (c > T_PWR) t = "R3";
      chk("R5 ready low", ready, 0);
      chk("R1 dqm high", dqm, {DQM_W{1'b1}});
    end else begin
      cmd_e = m_aref ? 4'b0001 : 4'b0111;
      t = r8_evt ? "R8" : "R7";
      chk("R5 ready high", ready, 1);
      chk("R5 dqm low", dqm, 0);
      chk("R6 req", req, owed > 0);
      chk(r10_evt ? "R10 miss" : "R9 miss", miss, owed > 0 ? owed - 1 : 0);
      chk("R9 sat", sat, m_sat);
    end
    chk({t, " cmd"}, {cs_n, ras_n, cas_n, we_n}, cmd_e);
    chk({t, " addr"}, addr, addr_e);
    chk({t, " ba"}, ba, 0);
    chk("R1 cke", cke, 1);
  end

  task automatic wait_cycle(input int target);
    while (c < target) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        wait_cycle(R_CYC + 5);
        grant = 1'b1; @(negedge clk); grant = 1'b0;          // R8: nothing owed
        while (!req) @(negedge clk);
        grant = 1'b1; repeat (6) @(negedge clk); grant = 1'b0; // R7: grants during busy
        wait_cycle(c + 2 * T_REFI);                           // owe two
        while (((c - R_CYC) % T_REFI) != T_REFI - 1) @(negedge clk);
        grant = 1'b1; @(negedge clk); grant = 1'b0;          // R10 coincidence
        wait_cycle(c + 7 * T_REFI);                           // R9 saturate
        grant = 1'b1; wait_cycle(c + 3 * T_REFI); grant = 1'b0;
        wait_cycle(c + 10);
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule